// File: doc/BRIEF.md
# Coherent Two-Stage Sample Result Bank

This block keeps the results of a multi-channel converter for a host that reads them over a serial link. Each finished conversion lands in a per-channel staging register as soon as it arrives. When the converter reports that its scan is over, the whole staged set moves into the host-visible result registers on a single clock edge. A host reading any mix of channels therefore always sees samples from one scan.

The host side can be moving data out at any time. While it signals that a transfer is under way, the visible results are frozen. An end-of-scan that arrives during a transfer is remembered. It is applied on the first edge where the transfer has ended, using whatever the staging registers hold at that moment.

A ready flag tells the host that a fresh set has been published. Any host read clears it. Results are read by channel number through a combinational multiplexer.

Top module: `sample_result_bank`

## Requirements
- R1: After reset all eight published results read as zero and `dataReady` is low.
- R2: A pulse on `wrValid` stores `wrData` into the staging register of channel `wrChan` only. No published result changes until a publish occurs.
- R3: When `scanDone` is sampled high with `xferBusy` low, all eight staged values are published on that edge. A write presented in the same cycle is included in what is published.
- R4: A channel not written during a scan publishes the staging value it already held, so its result stays unchanged.
- R5: While `xferBusy` is sampled high, no published result changes.
- R6: A `scanDone` seen while `xferBusy` is high is held as pending. Several such strobes collapse into one. The publish happens on the first edge where `xferBusy` is sampled low, using the staged values current at that edge, including writes made during the transfer.
- R7: `dataReady` is high in the cycle after each publish.
- R8: `rdStrobe` clears `dataReady` at the next edge. If a publish happens on the same edge, `dataReady` stays high.
- R9: `rdData` shows the published result of channel `rdAddr` in the same cycle. `rdAddr` is the binary channel number 0 to 7, and `rdData` is 10-bit straight binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | One conversion result is presented this cycle |
| wrChan | input | 3 | Channel number of the presented result |
| wrData | input | 10 | Presented conversion result |
| scanDone | input | 1 | The last channel of the scan has finished |
| xferBusy | input | 1 | Host serial transfer in progress; published results must hold |
| rdAddr | input | 3 | Channel number to read |
| rdStrobe | input | 1 | Host read of a result; clears the ready flag |
| rdData | output | 10 | Published result of channel `rdAddr` |
| dataReady | output | 1 | A fresh result set has been published and not yet read |

## Verification
Staging writes, publishes, the pending flag and `dataReady` all take effect on the edge where their strobe is sampled, so they become visible one cycle after the stimulus. `rdData` follows `rdAddr` within the same cycle. The bench drives its inputs at the falling edge and advances its own arithmetic model at the rising edge. It then sweeps all eight read addresses with short delays between them, while no strobe is active and `xferBusy` keeps its value. For a pending publish, the bench expects the update on the edge where `xferBusy` is first sampled low, and checks that nothing moved in each busy cycle before it.

// File: rtl/sample_bank_pkg.sv
package sample_bank_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic commit;   // copy all staged values into the published set
    logic freeze;   // host transfer under way; published set must hold
  } bankStrobes_t;
endpackage

// File: rtl/sample_bank_ctrl.sv
module sample_bank_ctrl
  import sample_bank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         scanDone,
  input  logic         xferBusy,
  input  logic         rdStrobe,
  output bankStrobes_t strobes,
  output logic         dataReady
);
  logic pending;
  logic wantCommit;

  assign wantCommit     = scanDone | pending;
  assign strobes.commit = wantCommit & ~xferBusy;
  assign strobes.freeze = xferBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (xferBusy) begin
      pending <= wantCommit;
    end else begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
    end else if (strobes.commit) begin
      dataReady <= 1'b1;
    end else if (rdStrobe) begin
      dataReady <= 1'b0;
    end
  end

  // R6: a held publish fires as soon as the transfer has ended
  a_r6_pending_fires: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !xferBusy) |=> (!pending && dataReady));

  // R6: end of scan during a transfer is remembered
  a_r6_pending_set: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && xferBusy) |=> pending);

  // R7: a publish raises the ready flag
  a_r7_ready_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> dataReady);

  // R8: a read with no publish clears the ready flag
  a_r8_ready_clear: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !strobes.commit) |=> !dataReady);
endmodule

// File: rtl/sample_bank_datapath.sv
module sample_bank_datapath
  import sample_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrChan,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_CH-1:0][DATA_W-1:0] stageRegs;
  logic [NUM_CH-1:0][DATA_W-1:0] stageNext;
  logic [NUM_CH-1:0][DATA_W-1:0] pubRegs;

  // Staged view including this cycle's write, so a publish sees it
  always_comb begin
    stageNext = stageRegs;
    if (wrValid) stageNext[wrChan] = wrData;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageRegs[ch] <= '0;
        pubRegs[ch]   <= '0;
      end else begin
        stageRegs[ch] <= stageNext[ch];
        if (strobes.commit) pubRegs[ch] <= stageNext[ch];
      end
    end
  end

  assign rdData = pubRegs[rdAddr];

  // R5: published set holds while a transfer is under way
  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobes.freeze |=> $stable(pubRegs));

  // R2: without a publish the published set does not move
  a_r2_no_commit_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(pubRegs));

  // R3: a publish copies the whole staged set, including a same-cycle write
  a_r3_atomic_copy: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (pubRegs == $past(stageNext)));
endmodule

// File: rtl/sample_result_bank.sv
module sample_result_bank
  import sample_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  parameter int ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrChan,
  input  logic [DATA_W-1:0] wrData,
  input  logic              scanDone,
  input  logic              xferBusy,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              dataReady
);
  bankStrobes_t strobes;

  sample_bank_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .scanDone  (scanDone),
    .xferBusy  (xferBusy),
    .rdStrobe  (rdStrobe),
    .strobes   (strobes),
    .dataReady (dataReady)
  );

  sample_bank_datapath #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrValid (wrValid),
    .wrChan  (wrChan),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );

  // R5: no publish is issued during a transfer
  a_r5_no_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |-> !strobes.commit);
endmodule

// File: tb/sample_result_bank_tb.sv
`timescale 1ns/1ps
module sample_result_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [2:0] wrChan = '0;
  logic [9:0] wrData = '0;
  logic       scanDone = 1'b0;
  logic       xferBusy = 1'b0;
  logic [2:0] rdAddr = '0;
  logic       rdStrobe = 1'b0;
  logic [9:0] rdData;
  logic       dataReady;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int  expStage [NCH];
  int  expPub [NCH];
  bit  expPend;
  bit  expReady;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_result_bank u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrChan(wrChan),
    .wrData(wrData), .scanDone(scanDone), .xferBusy(xferBusy),
    .rdAddr(rdAddr), .rdStrobe(rdStrobe), .rdData(rdData),
    .dataReady(dataReady)
  );

  task automatic modelReset();
    for (int i = 0; i < NCH; i++) begin
      expStage[i] = 0;
      expPub[i] = 0;
    end
    expPend = 0;
    expReady = 0;
  endtask

  // One clock: drive at falling edge, advance model at rising edge
  task automatic step(input bit v, input int ch, input int d,
                      input bit done, input bit busy, input bit rd);
    bit doCommit;
    @(negedge clk);
    wrValid  = v;
    wrChan   = 3'(ch);
    wrData   = 10'(d);
    scanDone = done;
    xferBusy = busy;
    rdStrobe = rd;
    @(posedge clk);
    if (v) expStage[ch] = d % 1024;
    doCommit = (done || expPend) && !busy;
    expPend  = busy ? (expPend || done) : 1'b0;
    if (doCommit) begin
      for (int i = 0; i < NCH; i++) expPub[i] = expStage[i];
      expReady = 1;
    end else if (rd) begin
      expReady = 0;
    end
    #1;
    wrValid  = 1'b0;
    scanDone = 1'b0;
    rdStrobe = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    total++;
    if (dataReady !== expReady) begin
      bad++;
      $display("FAIL %s ready: actual=%0b expected=%0b", tag, dataReady, expReady);
    end
    for (int a = 0; a < NCH; a++) begin
      rdAddr = 3'(a);
      #1;
      total++;
      if (rdData !== 10'(expPub[a])) begin
        bad++;
        $display("FAIL %s R9 ch%0d: actual=%0d expected=%0d", tag, a, rdData, expPub[a]);
      end
    end
  endtask

  function automatic int pat(input int k, input int ch);
    return (k * 131 + ch * 37 + 5) % 1024;
  endfunction

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkAll("R1 after release");

    // R2: a single staged write must not show
    step(1, 3, 777, 0, 0, 0);
    checkAll("R2 staged only");

    // R3: full scan, last write with scanDone in the same cycle
    for (int ch = 0; ch < 7; ch++) step(1, ch, pat(1, ch), 0, 0, 0);
    step(1, 7, pat(1, 7), 1, 0, 0);
    checkAll("R3 R7 full scan publish");

    // R8: read clears ready
    step(0, 0, 0, 0, 0, 1);
    checkAll("R8 read clears");

    // R4: partial scan, boundary values
    step(1, 2, 0, 0, 0, 0);
    step(1, 6, 1023, 1, 0, 0);
    checkAll("R4 partial scan");

    // R5/R6: scan ends during a transfer, more writes while busy
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0);
    for (int ch = 0; ch < 4; ch++) step(1, ch, pat(2, ch), ch == 3, 1, 0);
    checkAll("R5 frozen after scanDone");
    step(1, 7, 1023, 0, 1, 0);
    checkAll("R5 frozen while busy");
    step(1, 0, 0, 1, 1, 0);
    checkAll("R6 second scanDone held");
    step(0, 0, 0, 0, 0, 0);
    checkAll("R6 pending publish");

    // R8: read and publish on one edge keeps ready high
    step(1, 5, 512, 1, 0, 1);
    checkAll("R8 read with publish");

    // R2: staged write without scanDone after a read
    step(0, 0, 0, 0, 0, 1);
    step(1, 4, 1, 0, 0, 0);
    checkAll("R2 write no publish");

    // Sweep: scans of varying length, some spanning transfers
    for (int k = 3; k < 40; k++) begin
      bit busyScan = (k % 3 == 0);
      int n = (k % NCH) + 1;
      for (int ch = 0; ch < n; ch++)
        step(1, (ch * 3 + k) % NCH, pat(k, ch), ch == n - 1, busyScan, 0);
      if (busyScan) begin
        checkAll("R5 sweep frozen");
        step(0, 0, 0, 0, 0, 0);
        checkAll("R6 sweep release");
      end else begin
        checkAll("R3 R4 sweep publish");
      end
      step(0, 0, 0, 0, 0, (k % 2 == 0));
      checkAll("R8 sweep read");
    end

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    modelReset();
    #1;
    checkAll("R1 mid-run reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule